// File: doc/BRIEF.md
# Oversampled Audio Oscillator with FIR Decimation

This block is one audio voice. Each DAC period it produces one filtered output sample. When the DAC strobe `dac_en` arrives, a naive phase-accumulator oscillator writes a short burst of `OSR` raw samples into a circular sample ring. The oscillator is either a sawtooth or a square pulse, with no band limiting. At the same strobe, a single multiply-accumulate engine convolves the most recent `TAPS` ring entries, ending at the last sample of the burst that has just finished, with a symmetric triangular low-pass kernel. The result is rounded, clamped to 16 bits and issued as one sample, which decimates the raw stream by `OSR`.

Generation and filtering overlap. The burst being written sits ahead of the window being read, so each output reflects the burst made during the previous period: the latency is one DAC period. The ring holds at least `TAPS+OSR` entries, so the filter window reaches back across several earlier bursts. After reset the ring counts as empty. Positions not yet written read as zero, so the first output is exactly zero.

The output stream has no back-pressure. `out_valid` is high for a single clock, and the consumer must take `out_sample` in that cycle. `out_sample` holds its value until the next result. `dac_en` is a plain strobe. `overrun` is a plain status pulse.

Top module: `osc_fir_decim`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_sample` is 0, and `out_valid` and `overrun` are low. The phase restarts at 0.
- R2: Each `dac_en` starts a burst of `OSR` raw samples, written on the following `OSR` clocks. Raw sample m uses phase P_m, where P_0 = 0 and P_(m+1) = P_m + `phase_inc` modulo 2^32. The phase carries on across bursts. With `wave_sel` = 0 (sawtooth), the raw sample is P_m[31:16] read as two's complement.
- R3: With `wave_sel` = 1 (pulse), the raw sample is +32767 when P_m[31] is 0 and -32768 when it is 1.
- R4: The output for a strobe is the sum of w(k)·x[n-1-k] for k = 0..TAPS-1. Here n is the number of raw samples written before that strobe, x[i] = 0 for i < 0, and w(k) = min(k+1, TAPS-k).
- R5: The first output after reset is 0. Each later output covers exactly the raw samples produced after the previous strobes, so it lags generation by one DAC period.
- R6: `out_valid` rises exactly TAPS+2 clocks after the edge that samples `dac_en`, and stays high for exactly one clock. Each accepted strobe gives one pulse.
- R7: The sum is rounded by adding 2^(OUT_SHIFT-1) and then shifting right arithmetically by OUT_SHIFT.
- R8: The rounded value is clamped to the range -32768..32767.
- R9: A `dac_en` that arrives while a convolution is still in progress (before its result edge) raises `overrun` for one clock. The unfinished result is discarded, and a new convolution starts for the new strobe. On a strobe that does not collide, `overrun` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dac_en | input | 1 | One-clock strobe per DAC period |
| phase_inc | input | 32 | Phase step per raw sample |
| wave_sel | input | 1 | 0 = sawtooth, 1 = pulse |
| out_sample | output | 16 | Filtered, decimated signed sample |
| out_valid | output | 1 | One-clock strobe when `out_sample` is updated |
| overrun | output | 1 | One-clock pulse when a strobe interrupts a convolution |

## Verification
The bench builds the block with OSR = 4, TAPS = 15 and OUT_SHIFT = 5. With these values the filter window spans almost four bursts, so the empty-history start and the wrap of the 32-entry ring both appear within a few periods. The shift gives the kernel a gain of two, which lets a steady pulse level drive the output into both clamp limits. DAC periods of about twenty clocks are short enough to provoke an overrun on purpose, and leave room for long random runs.

// File: rtl/osc_fir_pkg.sv
package osc_fir_pkg;

  localparam int SAMPLE_W = 16;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  typedef enum logic {
    WAVE_SAW   = 1'b0,
    WAVE_PULSE = 1'b1
  } wave_e;

  localparam sample_t RAIL_HI = 16'sh7FFF;
  localparam sample_t RAIL_LO = 16'sh8000;

  // Triangular symmetric kernel: the index is folded about the centre tap.
  function automatic int unsigned tap_weight(int unsigned k, int unsigned taps);
    int unsigned mirror;
    mirror = taps - 1 - k;
    return (k < mirror) ? (k + 1) : (mirror + 1);
  endfunction

endpackage

// File: rtl/osc_phase_gen.sv
module osc_phase_gen
  import osc_fir_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int PH_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dac_en,
  input  logic [PH_W-1:0] phase_inc,
  input  wave_e           wave_sel,
  output logic            wr_en,
  output sample_t         wr_data
);

  localparam int CNT_W = $clog2(OSR + 1);

  logic [CNT_W-1:0] left;
  logic [PH_W-1:0]  phase;

  assign wr_en = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left  <= '0;
      phase <= '0;
    end else begin
      if (wr_en)
        phase <= phase + phase_inc;
      if (dac_en)
        left <= CNT_W'(OSR);
      else if (wr_en)
        left <= left - 1'b1;
    end
  end

  // Naive wave shaping straight from the phase, no band limiting.
  always_comb begin
    unique case (wave_sel)
      WAVE_PULSE: wr_data = phase[PH_W-1] ? RAIL_LO : RAIL_HI;
      default:    wr_data = sample_t'(phase[PH_W-1 -: SAMPLE_W]);
    endcase
  end

  a_r3_pulse_rails: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wave_sel == WAVE_PULSE) |-> (wr_data == RAIL_HI || wr_data == RAIL_LO));

  a_r2_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(left) <= OSR));

  a_r2_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(phase));

endmodule

// File: rtl/osc_sample_ring.sv
module osc_sample_ring
  import osc_fir_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sample_t           wr_data,
  output logic [ADDR_W-1:0] head,
  output logic [FILL_W-1:0] fill,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output sample_t           rd_data
);

  sample_t mem [DEPTH];

  // Storage itself is not cleared; the fill count marks what is real.
  always_ff @(posedge clk) begin
    if (wr_en)
      mem[head] <= wr_data;
    if (rd_en)
      rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      fill <= '0;
    end else if (wr_en) begin
      head <= head + 1'b1;
      if (32'(fill) < DEPTH)
        fill <= fill + 1'b1;
    end
  end

  a_r2_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (head == ADDR_W'($past(head) + 1'b1)));

  a_r4_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fill) <= DEPTH));

  a_r5_fill_grows_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(fill));

endmodule

// File: rtl/osc_fir_mac.sv
module osc_fir_mac
  import osc_fir_pkg::*;
#(
  parameter int TAPS      = 511,
  parameter int ADDR_W    = 10,
  parameter int FILL_W    = 11,
  parameter int ACC_W     = 48,
  parameter int OUT_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] head,
  input  logic [FILL_W-1:0] fill,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  sample_t           rd_data,
  output sample_t           out_sample,
  output logic              out_valid,
  output logic              overrun
);

  localparam int K_W  = $clog2(TAPS);
  localparam int HALF = (TAPS + 1) / 2;
  localparam int CW   = $clog2(HALF + 1);
  localparam logic signed [ACC_W-1:0] SAT_HI   = ACC_W'(32767);
  localparam logic signed [ACC_W-1:0] SAT_LO   = -(ACC_W'(32768));
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (OUT_SHIFT - 1);

  logic [K_W-1:0]          k;
  logic                    issuing;
  logic [ADDR_W-1:0]       base;
  logic [FILL_W-1:0]       live_n;
  logic                    p1_v, p1_live, p1_last;
  logic [CW-1:0]           p1_coef;
  logic signed [ACC_W-1:0] acc;
  logic                    acc_done;
  logic                    busy, k_last;
  sample_t                 samp;
  logic signed [ACC_W-1:0] samp_ext, coef_ext, term, rnd;
  sample_t                 sat_val;

  assign busy    = issuing | p1_v | acc_done;
  assign k_last  = (k == K_W'(TAPS - 1));
  assign rd_en   = issuing;
  assign rd_addr = base - ADDR_W'(k);

  // MAC datapath: a tap past the written history contributes zero.
  assign samp     = p1_live ? rd_data : '0;
  assign samp_ext = ACC_W'(samp);
  assign coef_ext = ACC_W'({1'b0, p1_coef});
  assign term     = samp_ext * coef_ext;

  // Round half up, then clamp into the 16-bit range.
  assign rnd = (acc + HALF_LSB) >>> OUT_SHIFT;
  always_comb begin
    if (rnd > SAT_HI)      sat_val = RAIL_HI;
    else if (rnd < SAT_LO) sat_val = RAIL_LO;
    else                   sat_val = sample_t'(rnd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k          <= '0;
      issuing    <= 1'b0;
      base       <= '0;
      live_n     <= '0;
      p1_v       <= 1'b0;
      p1_live    <= 1'b0;
      p1_last    <= 1'b0;
      p1_coef    <= '0;
      acc        <= '0;
      acc_done   <= 1'b0;
      out_sample <= '0;
      out_valid  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      overrun   <= start && busy && !acc_done;
      if (acc_done) begin
        out_sample <= sat_val;
        out_valid  <= 1'b1;
        acc_done   <= 1'b0;
      end
      if (start) begin
        issuing  <= 1'b1;
        k        <= '0;
        base     <= head - 1'b1;
        live_n   <= fill;
        p1_v     <= 1'b0;
        acc      <= '0;
        acc_done <= 1'b0;
      end else begin
        p1_v <= issuing;
        if (issuing) begin
          p1_live <= (32'(k) < 32'(live_n));
          p1_coef <= CW'(tap_weight(32'(k), TAPS));
          p1_last <= k_last;
          k       <= k + 1'b1;
          if (k_last)
            issuing <= 1'b0;
        end
        if (p1_v) begin
          acc <= acc + term;
          if (p1_last)
            acc_done <= 1'b1;
        end
      end
    end
  end

  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r9_overrun_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(start));

  a_r6_valid_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !issuing || $past(start));

  a_r8_output_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid) |=> (out_valid || $stable(out_sample)));

endmodule

// File: rtl/osc_fir_decim.sv
module osc_fir_decim
  import osc_fir_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int TAPS      = 511,
  parameter int ACC_W     = 48,
  parameter int OUT_SHIFT = 2 * $clog2((TAPS + 1) / 2)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dac_en,
  input  logic [31:0] phase_inc,
  input  logic        wave_sel,
  output logic [15:0] out_sample,
  output logic        out_valid,
  output logic        overrun
);

  localparam int DEPTH  = 1 << $clog2(TAPS + OSR);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic              wr_en;
  sample_t           wr_data;
  logic [ADDR_W-1:0] head;
  logic [FILL_W-1:0] fill;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  sample_t           rd_data;
  sample_t           fir_out;
  wave_e             wave;

  assign wave       = wave_e'(wave_sel);
  assign out_sample = fir_out;

  osc_phase_gen #(.OSR(OSR), .PH_W(32)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .dac_en    (dac_en),
    .phase_inc (phase_inc),
    .wave_sel  (wave),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  osc_sample_ring #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .FILL_W(FILL_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .head    (head),
    .fill    (fill),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  osc_fir_mac #(
    .TAPS(TAPS), .ADDR_W(ADDR_W), .FILL_W(FILL_W),
    .ACC_W(ACC_W), .OUT_SHIFT(OUT_SHIFT)
  ) u_fir (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (dac_en),
    .head       (head),
    .fill       (fill),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .out_sample (fir_out),
    .out_valid  (out_valid),
    .overrun    (overrun)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (out_sample == 16'd0 && !out_valid && !overrun));

endmodule

// File: tb/sim_osc_fir_decim.sv
module sim_osc_fir_decim;
  localparam int OSR  = 4;
  localparam int TAPS = 15;
  localparam int SH   = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dac_en = 1'b0;
  logic [31:0] phase_inc = '0;
  logic        wave_sel = 1'b0;
  logic [15:0] out_sample;
  logic        out_valid, overrun;

  always #5 clk = ~clk;

  osc_fir_decim #(.OSR(OSR), .TAPS(TAPS), .ACC_W(48), .OUT_SHIFT(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .dac_en(dac_en), .phase_inc(phase_inc),
    .wave_sel(wave_sel), .out_sample(out_sample), .out_valid(out_valid),
    .overrun(overrun)
  );

  int          vectors = 0;
  int          errors = 0;
  bit          done = 1'b0;
  int          hist [0:4095];
  int          n_hist = 0;
  logic [31:0] m_phase = '0;

  function automatic int weight(int k);
    return (k + 1 < TAPS - k) ? (k + 1) : (TAPS - k);
  endfunction

  function automatic int shape(logic [31:0] ph, logic sel);
    if (sel) return ph[31] ? -32768 : 32767;
    return int'($signed(ph[31:16]));
  endfunction

  function automatic int predict();
    longint acc = 0;
    for (int k = 0; k < TAPS; k++) begin
      int idx = n_hist - 1 - k;
      if (idx >= 0) acc += longint'(weight(k)) * longint'(hist[idx]);
    end
    acc = (acc + (longint'(1) <<< (SH - 1))) >>> SH;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_burst();
    for (int i = 0; i < OSR; i++) begin
      hist[n_hist] = shape(m_phase, wave_sel);
      n_hist++;
      m_phase = m_phase + phase_inc;
    end
  endtask

  task automatic strobe();
    @(negedge clk); dac_en = 1'b1;
    @(negedge clk); dac_en = 1'b0;
  endtask

  // One DAC period: strobe, wait for the result, check latency and value.
  task automatic period(string tag, int gap);
    int exp, lat;
    exp = predict();
    strobe();
    check("R9 no overrun", int'(overrun), 0);
    model_burst();
    lat = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (out_valid) begin lat = i; break; end
    end
    check("R6 latency", lat, TAPS + 2);
    check(tag, int'($signed(out_sample)), exp);
    @(negedge clk);
    check("R6 single pulse", int'(out_valid), 0);
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic steer_phase(logic [31:0] target);
    phase_inc = (target - m_phase) >> 2;
    period("R4 R7 steer", 2);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int exp2, lat;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 sample", int'(out_sample), 0);
    check("R1 valid", int'(out_valid), 0);
    check("R1 overrun", int'(overrun), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sample after release", int'(out_sample), 0);

    // R5: empty history first, then one-period lag
    phase_inc = 32'h0123_4567;
    wave_sel  = 1'b0;
    period("R5 first zero", 3);
    period("R5 lag R2", 3);
    period("R2 saw", 0);
    wave_sel = 1'b1;
    period("R3 pulse", 2);
    phase_inc = 32'h8000_0000;
    period("R3 alternating", 2);

    // R8: hold positive and negative rails
    wave_sel = 1'b1;
    steer_phase(32'h4000_0000);
    phase_inc = '0;
    for (int i = 0; i < 5; i++) period("R8 high clamp", 1);
    check("R8 high rail", int'($signed(out_sample)), 32767);
    steer_phase(32'hC000_0000);
    phase_inc = '0;
    for (int i = 0; i < 5; i++) period("R8 low clamp", 1);
    check("R8 low rail", int'($signed(out_sample)), -32768);

    // R9: strobe in the middle of a convolution
    phase_inc = 32'h0A00_0000;
    wave_sel  = 1'b0;
    strobe();
    model_burst();
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      check("R9 no early valid", int'(out_valid), 0);
    end
    exp2 = predict();
    strobe();
    check("R9 overrun pulse", int'(overrun), 1);
    model_burst();
    lat = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (i == 1) check("R9 overrun one cycle", int'(overrun), 0);
      if (out_valid) begin lat = i; break; end
    end
    check("R9 restart latency", lat, TAPS + 2);
    check("R9 restart value", int'($signed(out_sample)), exp2);
    repeat (3) @(negedge clk);

    // Random mix
    for (int t = 0; t < 60; t++) begin
      if ($urandom_range(0, 1) == 1) phase_inc = $urandom;
      else phase_inc = $urandom_range(0, 32'h0100_0000);
      wave_sel = 1'($urandom_range(0, 1));
      period("R4 R7 random", $urandom_range(0, 15));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule